// File: doc/BRIEF.md
# DRAM Clock Frequency Change Sequencer

This block lives on the controller side of a DDR2-style DRAM and steers the memory through a live change of its input clock frequency. When software logic pulses a request, the sequencer first makes sure every bank is closed. It issues a precharge-all if the caller reports an open bank, and skips that step otherwise. It then drops CKE, with ODT forced off, to put the device into precharge power-down.

After a short settle time at the old frequency, it tells an external clock generator that the frequency may now change. It then waits for that generator to report a stable new clock. Once the acknowledge arrives and one cycle of the new clock has passed, the sequencer raises CKE again and waits out the power-down exit latency with NOPs. It then loads the extended mode register with a DLL-reset word. If the caller asked for it, the sequencer also loads the main mode register with a new write-recovery value. Finally it holds ODT off for the whole DLL relock period, and then pulses done for one cycle.

Outside a sequence, the block passes the controller's own ODT request straight through and drives NOP with CKE high. A request that arrives while a sequence is running is dropped. All control pins are plain levels; no stream handshake exists at this edge.

Top module: `freq_change_seq`

## Requirements
- R1: While reset is asserted, and in idle after reset, the outputs are: cke_o = 1, command NOP, ba_o = 0, addr_o = 0, freq_chg_ok_o = 0 and done_o = 0. The command encoding on cmd_o is {ras_n, cas_n, we_n}, with NOP = 3'b111, PRECHARGE = 3'b010 and mode-register LOAD = 3'b000. In idle, odt_o equals odt_req_i. Asserting reset in the middle of a sequence returns cke_o to 1 at once.
- R2: A request is sampled at a clock edge while the block is idle. If bank_open_i = 1 at that edge, the next cycle carries PRECHARGE with addr_o = 14'h0400 (bit 10 selects all banks) and CKE high. T_RP = 3 NOP cycles with CKE high then follow before CKE falls. If bank_open_i = 0, CKE falls in the cycle right after the request edge and no PRECHARGE is issued.
- R3: Once CKE falls, it stays low for at least 3 cycles. In every cycle with CKE low, odt_o = 0 and the command is NOP.
- R4: freq_chg_ok_o rises after exactly T_PD_SETTLE = 2 cycles of CKE low. It stays high, with CKE low, until clk_stable_i is sampled high. It is low in the cycle after that sample.
- R5: After the stable acknowledge is sampled, CKE stays low for T_NEWCLK = 1 more cycle and then rises.
- R6: After CKE rises, T_XP = 2 NOP cycles follow with CKE high. The next cycle carries LOAD with ba_o = 2'b01 and addr_o = 14'h0004 (the DLL-reset word).
- R7: If wr_upd_i was 1 at the request edge, the cycle T_MRD + 1 = 3 cycles after the DLL-reset load carries LOAD with ba_o = 2'b00. Its addr_o equals 14'h0432 with bits 11:9 replaced by the wr_val_i captured at the request edge. If wr_upd_i was 0, every cycle of the relock period carries NOP.
- R8: done_o is high for exactly one cycle, T_RELOCK = 200 cycles after the DLL-reset load cycle. odt_o is 0 from the request until the done cycle, whatever odt_req_i is.
- R9: A request asserted while a sequence runs has no effect. The block returns to idle after done and stays there. The captured write-recovery value is not disturbed by inputs that change during the sequence.
- R10: Once CKE rises, it stays high for at least 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a frequency-change sequence (sampled in idle only) |
| bank_open_i | input | 1 | Some bank is open; a precharge-all is needed first |
| wr_upd_i | input | 1 | Also load the mode register with a new write-recovery value |
| wr_val_i | input | 3 | Write-recovery value placed in mode-register bits 11:9 |
| clk_stable_i | input | 1 | Clock generator reports the new clock is stable |
| odt_req_i | input | 1 | Controller's own ODT request, passed through in idle |
| cke_o | output | 1 | DRAM clock enable |
| odt_o | output | 1 | DRAM on-die termination |
| cmd_o | output | 3 | Command {ras_n, cas_n, we_n} |
| ba_o | output | 2 | Bank / register select |
| addr_o | output | 14 | Address bus |
| freq_chg_ok_o | output | 1 | Clock generator may change the frequency now |
| done_o | output | 1 | One-cycle pulse at the end of the relock period |

## Verification
All outputs are decoded from the state register without an extra stage. A wrong state therefore shows at the ports in the very cycle the state goes astray. A missing or extra wait cycle moves the CKE fall, the freq_chg_ok_o window, the CKE rise or the DLL-reset load by one cycle. The cycle-exact bench catches each of these on the first cycle of that phase. A slip in the relock counter moves done_o or the mode-register load within the 200-cycle window. A lost capture register shows as a wrong addr_o bits 11:9 on that load, and an ODT gate that is not engaged shows as odt_o following odt_req_i during power-down or relock.

// File: rtl/freq_seq_pkg.sv
package freq_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_TRP,
    ST_PDN,
    ST_FCHG,
    ST_NEWCLK,
    ST_XP,
    ST_DLLR,
    ST_MRD,
    ST_MRS,
    ST_RLK,
    ST_DONE
  } seq_state_e;

  localparam logic [2:0] CMD_NOP  = 3'b111;
  localparam logic [2:0] CMD_PRE  = 3'b010;
  localparam logic [2:0] CMD_LOAD = 3'b000;

  localparam logic [1:0] BA_MAIN_MR = 2'b00;
  localparam logic [1:0] BA_EXT_MR  = 2'b01;

endpackage

// File: rtl/fcs_timer.sv
module fcs_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= val_i;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> cnt_q == '0); // R2

endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import freq_seq_pkg::*;
#(
  parameter int T_RP        = 3,
  parameter int T_PD_SETTLE = 2,
  parameter int T_NEWCLK    = 1,
  parameter int T_XP        = 2,
  parameter int T_MRD       = 2,
  parameter int T_RELOCK    = 200,
  parameter int PH_W        = 4,
  parameter int RL_W        = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic            bank_open_i,
  input  logic            wr_upd_i,
  input  logic [2:0]      wr_val_i,
  input  logic            clk_stable_i,
  input  logic            ph_zero_i,
  input  logic            rl_zero_i,
  output seq_state_e      state_o,
  output logic            ph_load_o,
  output logic [PH_W-1:0] ph_val_o,
  output logic            rl_load_o,
  output logic [RL_W-1:0] rl_val_o,
  output logic [2:0]      wrv_o
);

  localparam logic [PH_W-1:0] LD_RP  = PH_W'(T_RP - 1);
  localparam logic [PH_W-1:0] LD_PD  = PH_W'(T_PD_SETTLE - 1);
  localparam logic [PH_W-1:0] LD_NEW = PH_W'(T_NEWCLK - 1);
  localparam logic [PH_W-1:0] LD_XP  = PH_W'(T_XP - 1);
  localparam logic [PH_W-1:0] LD_MRD = PH_W'(T_MRD - 1);
  localparam logic [RL_W-1:0] LD_RLK = RL_W'(T_RELOCK - 1);

  seq_state_e state_q, state_d;
  logic       upd_q;
  logic [2:0] wrv_q;

  always_comb begin
    state_d   = state_q;
    ph_load_o = 1'b0;
    ph_val_o  = '0;
    rl_load_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          if (bank_open_i) begin
            state_d = ST_PRE;
          end else begin
            state_d   = ST_PDN;
            ph_load_o = 1'b1;
            ph_val_o  = LD_PD;
          end
        end
      end
      ST_PRE: begin
        state_d   = ST_TRP;
        ph_load_o = 1'b1;
        ph_val_o  = LD_RP;
      end
      ST_TRP: begin
        if (ph_zero_i) begin
          state_d   = ST_PDN;
          ph_load_o = 1'b1;
          ph_val_o  = LD_PD;
        end
      end
      ST_PDN: begin
        if (ph_zero_i) state_d = ST_FCHG;
      end
      ST_FCHG: begin
        if (clk_stable_i) begin
          state_d   = ST_NEWCLK;
          ph_load_o = 1'b1;
          ph_val_o  = LD_NEW;
        end
      end
      ST_NEWCLK: begin
        if (ph_zero_i) begin
          state_d   = ST_XP;
          ph_load_o = 1'b1;
          ph_val_o  = LD_XP;
        end
      end
      ST_XP: begin
        if (ph_zero_i) begin
          state_d   = ST_DLLR;
          rl_load_o = 1'b1;
        end
      end
      ST_DLLR: begin
        if (upd_q) begin
          state_d   = ST_MRD;
          ph_load_o = 1'b1;
          ph_val_o  = LD_MRD;
        end else begin
          state_d = ST_RLK;
        end
      end
      ST_MRD: begin
        if (ph_zero_i) state_d = ST_MRS;
      end
      ST_MRS: begin
        state_d = ST_RLK;
      end
      ST_RLK: begin
        if (rl_zero_i) state_d = ST_DONE;
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign rl_val_o = LD_RLK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      upd_q   <= 1'b0;
      wrv_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_i) begin
        upd_q <= wr_upd_i;
        wrv_q <= wr_val_i;
      end
    end
  end

  assign state_o = state_q;
  assign wrv_o   = wrv_q;

  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(wrv_q) && $stable(upd_q))); // R9

  AST_FCHG_WAITS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FCHG && !clk_stable_i) |=> state_q == ST_FCHG); // R4

endmodule

// File: rtl/fcs_cmd_enc.sv
module fcs_cmd_enc
  import freq_seq_pkg::*;
#(
  parameter int              ADDR_W      = 14,
  parameter logic [ADDR_W-1:0] MR_BASE   = 14'h0432,
  parameter logic [ADDR_W-1:0] EMR_DLLRST = 14'h0004
) (
  input  seq_state_e        state_i,
  input  logic [2:0]        wrv_i,
  input  logic              odt_req_i,
  output logic              cke_o,
  output logic              odt_o,
  output logic [2:0]        cmd_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              freq_ok_o,
  output logic              done_o
);

  localparam int WR_LSB = 9;
  localparam int PRE_ALL_BIT = 10;

  logic [ADDR_W-1:0] mr_word;

  always_comb begin
    mr_word = MR_BASE;
    mr_word[WR_LSB +: 3] = wrv_i;
  end

  always_comb begin
    cke_o     = 1'b1;
    odt_o     = 1'b0;
    cmd_o     = CMD_NOP;
    ba_o      = '0;
    addr_o    = '0;
    freq_ok_o = 1'b0;
    done_o    = 1'b0;
    unique case (state_i)
      ST_IDLE:   odt_o = odt_req_i;
      ST_PRE: begin
        cmd_o  = CMD_PRE;
        addr_o[PRE_ALL_BIT] = 1'b1;
      end
      ST_PDN:    cke_o = 1'b0;
      ST_FCHG: begin
        cke_o     = 1'b0;
        freq_ok_o = 1'b1;
      end
      ST_NEWCLK: cke_o = 1'b0;
      ST_DLLR: begin
        cmd_o  = CMD_LOAD;
        ba_o   = BA_EXT_MR;
        addr_o = EMR_DLLRST;
      end
      ST_MRS: begin
        cmd_o  = CMD_LOAD;
        ba_o   = BA_MAIN_MR;
        addr_o = mr_word;
      end
      ST_DONE:   done_o = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/freq_change_seq.sv
module freq_change_seq
  import freq_seq_pkg::*;
#(
  parameter int                T_RP        = 3,
  parameter int                T_PD_SETTLE = 2,
  parameter int                T_NEWCLK    = 1,
  parameter int                T_XP        = 2,
  parameter int                T_MRD       = 2,
  parameter int                T_RELOCK    = 200,
  parameter int                ADDR_W      = 14,
  parameter logic [ADDR_W-1:0] MR_BASE     = 14'h0432,
  parameter logic [ADDR_W-1:0] EMR_DLLRST  = 14'h0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              bank_open_i,
  input  logic              wr_upd_i,
  input  logic [2:0]        wr_val_i,
  input  logic              clk_stable_i,
  input  logic              odt_req_i,
  output logic              cke_o,
  output logic              odt_o,
  output logic [2:0]        cmd_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              freq_chg_ok_o,
  output logic              done_o
);

  localparam int PH_SUM = T_RP + T_PD_SETTLE + T_NEWCLK + T_XP + T_MRD;
  localparam int PH_W   = $clog2(PH_SUM + 1);
  localparam int RL_W   = $clog2(T_RELOCK + 1);

  seq_state_e      state;
  logic            ph_load, rl_load, ph_zero, rl_zero;
  logic [PH_W-1:0] ph_val;
  logic [RL_W-1:0] rl_val;
  logic [2:0]      wrv;

  fcs_ctrl #(
    .T_RP(T_RP), .T_PD_SETTLE(T_PD_SETTLE), .T_NEWCLK(T_NEWCLK),
    .T_XP(T_XP), .T_MRD(T_MRD), .T_RELOCK(T_RELOCK),
    .PH_W(PH_W), .RL_W(RL_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .bank_open_i(bank_open_i),
    .wr_upd_i(wr_upd_i), .wr_val_i(wr_val_i), .clk_stable_i(clk_stable_i),
    .ph_zero_i(ph_zero), .rl_zero_i(rl_zero), .state_o(state),
    .ph_load_o(ph_load), .ph_val_o(ph_val), .rl_load_o(rl_load),
    .rl_val_o(rl_val), .wrv_o(wrv)
  );

  fcs_timer #(.W(PH_W)) u_phase_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(ph_load), .val_i(ph_val), .zero_o(ph_zero)
  );

  fcs_timer #(.W(RL_W)) u_relock_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(rl_load), .val_i(rl_val), .zero_o(rl_zero)
  );

  fcs_cmd_enc #(
    .ADDR_W(ADDR_W), .MR_BASE(MR_BASE), .EMR_DLLRST(EMR_DLLRST)
  ) u_enc (
    .state_i(state), .wrv_i(wrv), .odt_req_i(odt_req_i),
    .cke_o(cke_o), .odt_o(odt_o), .cmd_o(cmd_o), .ba_o(ba_o),
    .addr_o(addr_o), .freq_ok_o(freq_chg_ok_o), .done_o(done_o)
  );

  AST_CKE_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke_o) |-> (!cke_o ##1 !cke_o ##1 !cke_o)); // R3

  AST_CKE_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_o) |-> (cke_o ##1 cke_o ##1 cke_o)); // R10

  AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_o |-> (!odt_o && cmd_o == CMD_NOP)); // R3

  AST_FCHG_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
    freq_chg_ok_o |-> (!cke_o && !odt_o)); // R4

  AST_ACK_DROPS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_chg_ok_o && clk_stable_i) |=> !freq_chg_ok_o); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

endmodule

// File: tb/freq_change_seq_bench.sv
module freq_change_seq_bench;

  localparam int T_RP = 3, T_PD = 2, T_NEW = 1, T_XP = 2, T_MRD = 2, T_RLK = 200;
  localparam logic [13:0] MRB = 14'h0432;
  localparam logic [13:0] EMR = 14'h0004;
  localparam logic [2:0] NOP = 3'b111, PRE = 3'b010, LOAD = 3'b000;

  // {bank_open, wr_upd, wr_val[2:0], ack_delay[2:0], odt_req}
  localparam int NV = 5;
  localparam logic [8:0] VEC_TBL [NV] = '{
    {1'b1, 1'b1, 3'b101, 3'd0, 1'b1},
    {1'b0, 1'b0, 3'b010, 3'd2, 1'b1},
    {1'b1, 1'b0, 3'b111, 3'd5, 1'b0},
    {1'b0, 1'b1, 3'b000, 3'd1, 1'b1},
    {1'b0, 1'b1, 3'b110, 3'd3, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, bank_open = 1'b0, wr_upd = 1'b0, clk_stable = 1'b0, odt_req = 1'b0;
  logic [2:0] wr_val = '0;
  logic cke, odt, fok, done;
  logic [2:0] cmd;
  logic [1:0] ba;
  logic [13:0] addr;

  int n_chk = 0, n_bad = 0;
  bit fin = 1'b0;

  always #4 clk = ~clk;

  freq_change_seq u_freq_change_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req), .bank_open_i(bank_open),
    .wr_upd_i(wr_upd), .wr_val_i(wr_val), .clk_stable_i(clk_stable),
    .odt_req_i(odt_req), .cke_o(cke), .odt_o(odt), .cmd_o(cmd), .ba_o(ba),
    .addr_o(addr), .freq_chg_ok_o(fok), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_bus(input string tag, input logic [2:0] ec, input logic [1:0] eb, input logic [13:0] ea);
    chk({cmd, ba, addr} == {ec, eb, ea}, tag, {13'b0, cmd, ba, addr}, {13'b0, ec, eb, ea});
  endtask

  task automatic report;
    if (!fin) begin
      fin = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic run_vec(input logic [8:0] v);
    logic bo, up, od;
    logic [2:0] wv, ad;
    logic [13:0] mr;
    {bo, up, wv, ad, od} = v;
    mr = {MRB[13:12], wv, MRB[8:0]};
    odt_req = od; bank_open = bo; wr_upd = up; wr_val = wv; req = 1'b1;
    @(posedge clk); @(negedge clk);
    req = 1'b0; bank_open = 1'b0; wr_upd = ~up; wr_val = ~wv;
    if (bo) begin
      chk(cke == 1'b1, "R2 cke high at precharge", cke, 1);
      chk_bus("R2 precharge-all", PRE, 2'b00, 14'h0400);
      for (int i = 0; i < T_RP; i++) begin
        @(negedge clk);
        chk(cke == 1'b1, "R2 cke high in tRP", cke, 1);
        chk_bus("R2 nop in tRP", NOP, 2'b00, 14'h0);
      end
      @(negedge clk);
    end
    for (int i = 0; i < T_PD; i++) begin
      if (i > 0) @(negedge clk);
      chk(cke == 1'b0, "R2 cke low", cke, 0);
      chk(fok == 1'b0, "R4 ok low during settle", fok, 0);
      chk(odt == 1'b0, "R3 odt off in power-down", odt, 0);
      chk_bus("R3 nop in power-down", NOP, 2'b00, 14'h0);
    end
    @(negedge clk);
    for (int j = 0; j <= int'(ad); j++) begin
      if (j > 0) @(negedge clk);
      chk(fok == 1'b1, "R4 ok high until ack", fok, 1);
      chk(cke == 1'b0, "R4 cke low while ok", cke, 0);
    end
    clk_stable = 1'b1;
    @(negedge clk);
    clk_stable = 1'b0;
    for (int i = 0; i < T_NEW; i++) begin
      if (i > 0) @(negedge clk);
      chk(fok == 1'b0, "R4 ok drops after ack", fok, 0);
      chk(cke == 1'b0, "R5 cke low on new clock", cke, 0);
    end
    for (int i = 0; i < T_XP; i++) begin
      @(negedge clk);
      chk(cke == 1'b1, "R5 cke rises", cke, 1);
      chk_bus("R6 nop in exit latency", NOP, 2'b00, 14'h0);
    end
    @(negedge clk);
    chk_bus("R6 dll reset load", LOAD, 2'b01, EMR);
    chk(odt == 1'b0, "R8 odt off at dll reset", odt, 0);
    for (int t = 1; t <= T_RLK; t++) begin
      @(negedge clk);
      req = (t == 1);
      if (up && t == T_MRD + 1) chk_bus("R7 write-recovery load", LOAD, 2'b00, mr);
      else                      chk_bus("R7 nop in relock", NOP, 2'b00, 14'h0);
      chk(done == (t == T_RLK), "R8 done timing", done, (t == T_RLK));
      chk(odt == 1'b0, "R8 odt off in relock", odt, 0);
      chk(cke == 1'b1, "R10 cke high in relock", cke, 1);
    end
    req = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(cke == 1'b1 && done == 1'b0, "R9 idle after done", {cke, done}, 2'b10);
      chk(odt == od, "R1 odt passthrough in idle", odt, od);
      chk_bus("R9 nop in idle", NOP, 2'b00, 14'h0);
    end
  endtask

  initial begin
    odt_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(cke == 1'b1, "R1 cke in reset", cke, 1);
    chk(fok == 1'b0 && done == 1'b0, "R1 flags in reset", {fok, done}, 0);
    chk_bus("R1 bus in reset", NOP, 2'b00, 14'h0);
    chk(odt == 1'b1, "R1 odt passthrough", odt, 1);
    rst_n = 1'b1;
    @(negedge clk);
    odt_req = 1'b0;
    @(negedge clk);
    chk(odt == 1'b0, "R1 odt passthrough low", odt, 0);

    for (int k = 0; k < NV; k++) run_vec(VEC_TBL[k]);

    // reset during power-down
    req = 1'b1; bank_open = 1'b0;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    chk(cke == 1'b0, "R2 cke low direct entry", cke, 0);
    #1 rst_n = 1'b0;
    #1 chk(cke == 1'b1, "R1 reset restores cke", cke, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cke == 1'b1 && fok == 1'b0, "R1 idle after reset", {cke, fok}, 2'b10);

    // sequence after reset still works
    run_vec({1'b0, 1'b1, 3'b011, 3'd0, 1'b0});
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      report();
    end
  end

endmodule